// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This combinational unit handles the bit-manipulation instruction group of a small 8-bit processor core. Given an operation code, a bit index, the operand byte, the incoming condition flags and a qualifier marking the short accumulator-only rotate encodings, it returns the new byte, a strobe telling the register file or memory sequencer to store that byte, and the new flag nibble.

The operations are four rotates (circular or through carry, each left or right), three shifts (arithmetic left, arithmetic right, logical right), a nibble exchange, and three single-bit operations: test, clear and set. The core fetches the operand and handles any read-modify-write sequencing. The unit only computes.

Operation codes on `opSel`: 0 rotate-left-circular, 1 rotate-right-circular, 2 rotate-left-through-carry, 3 rotate-right-through-carry, 4 arithmetic shift left, 5 arithmetic shift right, 6 nibble swap, 7 logical shift right, 8 bit test, 9 bit clear, 10 bit set. Codes 11 to 15 are unused. The flag nibble is {Z, N, H, C}: Z is bit 3, N is bit 2, H is bit 1 and C is bit 0.

Top module: `rsbu_top`

## Requirements
- R1: Left rotates. Code 0 moves bit 7 into both bit 0 and C. Code 2 moves the old C into bit 0 and bit 7 into C.
- R2: Right rotates. Code 1 moves bit 0 into both bit 7 and C. Code 3 moves the old C into bit 7 and bit 0 into C.
- R3: Code 4 shifts left, inserts 0 at bit 0 and moves bit 7 into C.
- R4: Code 5 shifts right, keeps bit 7 and moves bit 0 into C. Code 7 shifts right, inserts 0 at bit 7 and moves bit 0 into C.
- R5: Code 6 exchanges bits 7:4 with bits 3:0. It sets Z (flag bit 3) when the result is zero and clears N, H and C.
- R6: Codes 0 to 5 and 7 clear N (bit 2) and H (bit 1). When `accForm` is 0 they set Z when the result is zero. When `accForm` is 1 and the code is 0 to 3, Z is 0.
- R7: Code 8 sets Z to the inverse of operand bit `bitIdx`, forces N=0 and H=1, and keeps C. `resultWe` is 0 and `result` equals the operand.
- R8: Code 9 clears and code 10 sets operand bit `bitIdx`, where index 0 is the least significant bit. Both leave all four flags unchanged.
- R9: `resultWe` is 1 for codes 0 to 7, 9 and 10.
- R10: `accForm` has no effect for codes 4 to 15.
- R11: Codes 11 to 15 return the operand unchanged, keep the flags and hold `resultWe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| bitIdx | input | 3 | Bit index for test, clear and set |
| operand | input | 8 | Input byte |
| flagsIn | input | 4 | Incoming flags {Z,N,H,C} |
| accForm | input | 1 | Selects the short accumulator rotate form |
| result | output | 8 | Output byte |
| resultWe | output | 1 | Store strobe for `result` |
| flagsOut | output | 4 | Updated flags {Z,N,H,C} |

## Verification
Directed cases use operands with only bit 7 or only bit 0 set. These show whether a bit leaves through the carry or wraps around, and they make zero results that separate the general Z rule from the accumulator-form rule. Operand 0x81 with both carry values separates the arithmetic right shift from the logical one and separates circular rotates from through-carry rotates. Random operands, indices, flags and qualifier values across all sixteen codes cover the rest, including the unused codes and the claim that the qualifier does nothing outside the rotates.

// File: rtl/rsbu_pkg.sv
package rsbu_pkg;
  localparam logic [3:0] OP_RLC  = 4'd0;
  localparam logic [3:0] OP_RRC  = 4'd1;
  localparam logic [3:0] OP_RL   = 4'd2;
  localparam logic [3:0] OP_RR   = 4'd3;
  localparam logic [3:0] OP_SLA  = 4'd4;
  localparam logic [3:0] OP_SRA  = 4'd5;
  localparam logic [3:0] OP_SWAP = 4'd6;
  localparam logic [3:0] OP_SRL  = 4'd7;
  localparam logic [3:0] OP_BIT  = 4'd8;
  localparam logic [3:0] OP_RES  = 4'd9;
  localparam logic [3:0] OP_SET  = 4'd10;

  localparam logic [2:0] SK_LCIRC  = 3'd0;
  localparam logic [2:0] SK_RCIRC  = 3'd1;
  localparam logic [2:0] SK_LCARRY = 3'd2;
  localparam logic [2:0] SK_RCARRY = 3'd3;
  localparam logic [2:0] SK_ASL    = 3'd4;
  localparam logic [2:0] SK_ASR    = 3'd5;
  localparam logic [2:0] SK_LSR    = 3'd6;

  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

  typedef struct packed {
    logic       doShift;
    logic [2:0] shiftKind;
    logic       doSwap;
    logic       doTest;
    logic       doClear;
    logic       doSetBit;
    logic       zeroFromResult;
    logic       writeEn;
  } rsbu_strobes_t;
endpackage

// File: rtl/rsbu_ctrl.sv
module rsbu_ctrl
  import rsbu_pkg::*;
(
  input  logic [3:0]    opSel,
  input  logic          accForm,
  output rsbu_strobes_t strobes
);
  rsbu_strobes_t st;

  always_comb begin
    st = '0;
    st.zeroFromResult = 1'b1;
    unique case (opSel)
      OP_RLC, OP_RRC, OP_RL, OP_RR: begin
        st.doShift = 1'b1;
        st.writeEn = 1'b1;
        st.zeroFromResult = !accForm;
        st.shiftKind = (opSel == OP_RLC) ? SK_LCIRC  :
                       (opSel == OP_RRC) ? SK_RCIRC  :
                       (opSel == OP_RL)  ? SK_LCARRY : SK_RCARRY;
      end
      OP_SLA: begin st.doShift = 1'b1; st.writeEn = 1'b1; st.shiftKind = SK_ASL; end
      OP_SRA: begin st.doShift = 1'b1; st.writeEn = 1'b1; st.shiftKind = SK_ASR; end
      OP_SRL: begin st.doShift = 1'b1; st.writeEn = 1'b1; st.shiftKind = SK_LSR; end
      OP_SWAP: begin st.doSwap = 1'b1; st.writeEn = 1'b1; end
      OP_BIT:  st.doTest = 1'b1;
      OP_RES:  begin st.doClear = 1'b1;  st.writeEn = 1'b1; end
      OP_SET:  begin st.doSetBit = 1'b1; st.writeEn = 1'b1; end
      default: st.writeEn = 1'b0;
    endcase
    strobes = st;

    if (!$isunknown({opSel, accForm})) begin
      // bit test never requests a store
      assert_test_no_write_R7: assert (!(opSel == OP_BIT && st.writeEn));
      // codes above the last defined one select nothing
      assert_unused_idle_R11: assert (opSel <= OP_SET ||
        $countones({st.doShift, st.doSwap, st.doTest, st.doClear, st.doSetBit, st.writeEn}) == 0);
      assert_one_unit_R9: assert ($onehot0({st.doShift, st.doSwap, st.doTest, st.doClear, st.doSetBit}));
    end
  end
endmodule

// File: rtl/rsbu_dp.sv
module rsbu_dp
  import rsbu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  rsbu_strobes_t     strobes,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] res;
  logic [3:0]        flg;
  logic              carryOut;
  logic              cIn;
  logic              selBit;

  always_comb begin
    cIn = flagsIn[FLAG_C];
    for (int i = 0; i < DATA_W; i++) mask[i] = (bitIdx == IDX_W'(i));
    selBit = |(operand & mask);

    unique case (strobes.shiftKind)
      SK_LCIRC:  begin shifted = {operand[DATA_W-2:0], operand[DATA_W-1]}; carryOut = operand[DATA_W-1]; end
      SK_RCIRC:  begin shifted = {operand[0], operand[DATA_W-1:1]};        carryOut = operand[0]; end
      SK_LCARRY: begin shifted = {operand[DATA_W-2:0], cIn};               carryOut = operand[DATA_W-1]; end
      SK_RCARRY: begin shifted = {cIn, operand[DATA_W-1:1]};               carryOut = operand[0]; end
      SK_ASL:    begin shifted = {operand[DATA_W-2:0], 1'b0};              carryOut = operand[DATA_W-1]; end
      SK_ASR:    begin shifted = {operand[DATA_W-1], operand[DATA_W-1:1]}; carryOut = operand[0]; end
      SK_LSR:    begin shifted = {1'b0, operand[DATA_W-1:1]};              carryOut = operand[0]; end
      default:   begin shifted = operand;                                  carryOut = cIn; end
    endcase

    swapped = {operand[HALF-1:0], operand[DATA_W-1:HALF]};

    res = operand;
    flg = flagsIn;
    if (strobes.doShift) begin
      res = shifted;
      flg[FLAG_Z] = strobes.zeroFromResult && (shifted == '0);
      flg[FLAG_N] = 1'b0;
      flg[FLAG_H] = 1'b0;
      flg[FLAG_C] = carryOut;
    end else if (strobes.doSwap) begin
      res = swapped;
      flg = {(swapped == '0), 3'b000};
    end else if (strobes.doTest) begin
      flg[FLAG_Z] = !selBit;
      flg[FLAG_N] = 1'b0;
      flg[FLAG_H] = 1'b1;
    end else if (strobes.doClear) begin
      res = operand & ~mask;
    end else if (strobes.doSetBit) begin
      res = operand | mask;
    end

    result   = res;
    flagsOut = flg;

    if (!$isunknown({strobes, bitIdx, operand, flagsIn})) begin
      // circular rotates neither lose nor gain a one
      assert_circ_keeps_ones_R1: assert (!(strobes.doShift &&
        (strobes.shiftKind == SK_LCIRC || strobes.shiftKind == SK_RCIRC)) ||
        $countones(res) == $countones(operand));
      assert_shift_nh_clear_R6: assert (!strobes.doShift || (flg[FLAG_N] == 1'b0 && flg[FLAG_H] == 1'b0));
      assert_swap_inverse_R5: assert (!strobes.doSwap || {res[HALF-1:0], res[DATA_W-1:HALF]} == operand);
      assert_test_keeps_carry_R7: assert (!strobes.doTest ||
        (flg[FLAG_C] == flagsIn[FLAG_C] && flg[FLAG_H] && res == operand));
      assert_bitop_flags_kept_R8: assert (!(strobes.doClear || strobes.doSetBit) ||
        (flg == flagsIn && $countones(res ^ operand) <= 1));
    end
  end
endmodule

// File: rtl/rsbu_top.sv
module rsbu_top
  import rsbu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [3:0]        opSel,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flagsIn,
  input  logic              accForm,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [3:0]        flagsOut
);
  rsbu_strobes_t strobes;

  rsbu_ctrl u_ctrl (
    .opSel   (opSel),
    .accForm (accForm),
    .strobes (strobes)
  );

  rsbu_dp #(.DATA_W(DATA_W)) u_dp (
    .strobes  (strobes),
    .bitIdx   (bitIdx),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  assign resultWe = strobes.writeEn;
endmodule

// File: tb/sim_rsbu_top.sv
module sim_rsbu_top;
  logic       clk = 1'b0;
  logic [3:0] opSel = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] operand = '0;
  logic [3:0] flagsIn = '0;
  logic       accForm = 1'b0;
  logic [7:0] result;
  logic       resultWe;
  logic [3:0] flagsOut;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rsbu_top u0 (
    .opSel(opSel), .bitIdx(bitIdx), .operand(operand), .flagsIn(flagsIn),
    .accForm(accForm), .result(result), .resultWe(resultWe), .flagsOut(flagsOut)
  );

  // returns {we, flags[3:0], result[7:0]}
  function automatic logic [12:0] model(input logic [3:0] op, input logic [2:0] idx,
                                        input logic [7:0] a, input logic [3:0] f, input logic acc);
    logic [8:0] wide;
    logic [7:0] r;
    logic z, n, h, c, we;
    z = f[3]; n = f[2]; h = f[1]; c = f[0];
    r = a; we = 1'b1;
    case (op)
      4'd0: begin r = (a << 1) | (a >> 7); c = a[7]; end
      4'd1: begin r = (a >> 1) | (a << 7); c = a[0]; end
      4'd2: begin wide = {a, f[0]} ; r = wide[7:0]; c = a[7]; end
      4'd3: begin wide = {f[0], a}; r = wide[8:1]; c = a[0]; end
      4'd4: begin r = a << 1; c = a[7]; end
      4'd5: begin r = 8'($signed(a) >>> 1); c = a[0]; end
      4'd7: begin r = a >> 1; c = a[0]; end
      default: ;
    endcase
    if (op <= 4'd7 && op != 4'd6) begin
      n = 0; h = 0;
      z = (op <= 4'd3 && acc) ? 1'b0 : (r == 8'h00);
    end else if (op == 4'd6) begin
      r = {a[3:0], a[7:4]}; z = (r == 8'h00); n = 0; h = 0; c = 0;
    end else if (op == 4'd8) begin
      z = ((a >> idx) & 8'h01) == 8'h00; n = 0; h = 1; we = 0;
    end else if (op == 4'd9) begin
      r = a & ~(8'h01 << idx);
    end else if (op == 4'd10) begin
      r = a | (8'h01 << idx);
    end else begin
      we = 0;
    end
    return {we, z, n, h, c, r};
  endfunction

  function automatic string reqOf(input logic [3:0] op, input logic acc);
    if (op >= 4'd11) return "R11";
    if (op == 4'd8) return "R7";
    if (op == 4'd9 || op == 4'd10) return "R8";
    if (op == 4'd6) return "R5";
    if (acc && op >= 4'd4) return "R10";
    if (op == 4'd0 || op == 4'd2) return "R1";
    if (op == 4'd1 || op == 4'd3) return "R2";
    if (op == 4'd4) return "R3";
    return "R4";
  endfunction

  task automatic run(input logic [3:0] op, input logic [2:0] idx, input logic [7:0] a,
                     input logic [3:0] f, input logic acc);
    logic [12:0] exp;
    string tag;
    @(negedge clk);
    opSel = op; bitIdx = idx; operand = a; flagsIn = f; accForm = acc;
    #2;
    exp = model(op, idx, a, f, acc);
    tag = reqOf(op, acc);
    checks++;
    if (result !== exp[7:0]) begin
      fails++;
      $display("FAIL %s result op=%0d a=%h: got %h exp %h", tag, op, a, result, exp[7:0]);
    end
    checks++;
    if (flagsOut !== exp[11:8]) begin
      fails++;
      // Z rule of R6 shares this check for rotates and shifts
      $display("FAIL %s/R6 flags op=%0d a=%h acc=%0b: got %b exp %b", tag, op, a, acc, flagsOut, exp[11:8]);
    end
    checks++;
    if (resultWe !== exp[12]) begin
      fails++;
      $display("FAIL R9 %s write op=%0d: got %b exp %b", tag, op, resultWe, exp[12]);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed corner cases
    run(4'd2, 3'd0, 8'h80, 4'b0000, 1'b0); // R1 RL: 0x00, Z=1, C=1
    run(4'd2, 3'd0, 8'h80, 4'b0000, 1'b1); // R6 acc form: Z forced 0
    run(4'd0, 3'd0, 8'h81, 4'b1110, 1'b0); // R1 RLC: 0x03, C=1
    run(4'd3, 3'd0, 8'h01, 4'b0001, 1'b0); // R2 RR: 0x80, C=1
    run(4'd1, 3'd0, 8'h01, 4'b0000, 1'b1); // R2 RRC acc form
    run(4'd3, 3'd0, 8'h01, 4'b0000, 1'b0); // R2 RR to zero: Z=1
    run(4'd4, 3'd0, 8'h80, 4'b0110, 1'b0); // R3 SLA to zero
    run(4'd5, 3'd0, 8'h81, 4'b0000, 1'b0); // R4 SRA: 0xC0, C=1
    run(4'd7, 3'd0, 8'h81, 4'b0001, 1'b0); // R4 SRL: 0x40, C=1
    run(4'd7, 3'd0, 8'h01, 4'b0000, 1'b0); // R4 SRL to zero
    run(4'd6, 3'd0, 8'hF0, 4'b1111, 1'b0); // R5 swap clears NHC
    run(4'd6, 3'd0, 8'h00, 4'b0111, 1'b0); // R5 swap zero: Z=1
    run(4'd8, 3'd7, 8'h7F, 4'b0001, 1'b0); // R7 bit 7 clear: Z=1, C kept
    run(4'd8, 3'd0, 8'h01, 4'b1100, 1'b0); // R7 bit 0 set: Z=0
    run(4'd9, 3'd0, 8'hFF, 4'b1010, 1'b0); // R8 clear bit 0
    run(4'd10, 3'd7, 8'h00, 4'b0101, 1'b0); // R8 set bit 7
    run(4'd4, 3'd0, 8'h80, 4'b0000, 1'b1); // R10 acc ignored on SLA: Z=1
    run(4'd13, 3'd2, 8'h5A, 4'b1011, 1'b1); // R11 unused code
    // random sweep
    for (int k = 0; k < 4000; k++) begin
      run(4'($urandom), 3'($urandom), 8'($urandom), 4'($urandom), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule